// File: doc/BRIEF.md
# OTP PROM programming sequencer

This block programs an external byte-wide one-time-programmable memory without help from software. A start pulse makes it walk every address from zero up to the top of the array. At each address it first asks a request/response port for the byte that belongs there. It then drives the address and data buses with the programming supply selected and lowers the active-low program strobe for a fixed number of clock cycles. After that it releases the data bus, lowers the output-enable strobe and compares the byte it reads back with the one it wanted. A mismatch starts another pulse at the same address, up to a hard limit of attempts. A match moves on to the next address.

When the last address has been written, the sequencer drops the programming-supply select so that the memory runs at its normal 5 V supply. It then reads every location once more and compares each against the expected stream, with no program pulse in this pass. If requested at start, it then writes the security cell as the final step. This write uses one fixed all-ones address, a fixed byte and a dedicated select line, and it has no read-back, because reading is disabled once the cell is set. A done flag means that every step succeeded. A fail flag stops the sequence and holds the address that failed.

The pulse length is derived from the clock frequency and a pulse duration in nanoseconds. The default gives 0.1 ms at 125 MHz. Generating the analog voltages is outside this block.

Top module: `otp_seq`

## Requirements
- R1: Each program pulse holds pgm_n low for exactly PULSE_CYC = CLK_MHZ*PULSE_NS/1000 cycles. During the pulse, vpp_hi=1, mem_dq_oe=1 and oe_n=1, and mem_addr and mem_dq_out stay stable.
- R2: After every array pulse, the block reads the addressed byte with oe_n low and mem_dq_oe low for ACC_CYC cycles. It compares the byte on mem_dq_in with the expected byte in the last cycle of that read.
- R3: On a read-back mismatch, the block pulses the same address again, with at most MAX_TRIES pulses per address in total. An address that matches on pulse MAX_TRIES still passes.
- R4: On a match, the block moves to the next address. Addresses are programmed in ascending order from 0 to 2**ADDR_W-1, and afterwards each location holds its expected byte.
- R5: After the last address, a verify pass reads every address once in ascending order with vpp_hi=0 and issues no program pulse.
- R6: After MAX_TRIES failed attempts at one address, the block stops: fail=1, fail_addr holds that address, done=0, and no further pulse or read occurs.
- R7: A mismatch in the verify pass sets fail=1 with fail_addr set to that address and ends the run.
- R8: If sec_en is 1 at start and verify succeeds, the block issues exactly one further pulse. During that pulse sec_sel=1, mem_addr is all ones and mem_dq_out=SEC_BYTE, and no read follows.
- R9: done=1 only after both passes (and the security write, if requested) finish without error. done and fail are never both 1.
- R10: start is ignored while busy=1. A start in idle, done or fail clears both flags and begins again at address 0.
- R11: While reset is asserted and afterwards until start: busy=0, done=0, fail=0, pgm_n=1, oe_n=1, vpp_hi=0, req_valid=0.
- R12: req_valid stays high with req_addr stable until rsp_valid=1. The expected byte is the rsp_data of that cycle, and req_valid is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| sec_en | input | 1 | Write the security cell at the end of the run |
| req_valid | output | 1 | Expected-byte request pending |
| req_addr | output | ADDR_W | Address whose expected byte is requested |
| rsp_valid | input | 1 | Expected byte available |
| rsp_data | input | DATA_W | Expected byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data read from the memory |
| pgm_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | Output-enable strobe, active low |
| vpp_hi | output | 1 | 1 selects the programming supply, 0 the normal supply |
| sec_sel | output | 1 | Security cell is the target of the current pulse |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished without error |
| fail | output | 1 | Run stopped on an error |
| fail_addr | output | ADDR_W | Address at which the run stopped |

## Verification
The memory model marks one chosen address as needing a set number of pulses before it accepts a byte, and it writes bits only from 1 to 0. Setting that number to 1, to exactly the attempt limit and to one above it separates a clean walk, a pass on the last permitted attempt and a stop with the right failing address. A model option that disturbs read data only when the programming supply is deselected shows whether the verify pass really runs at the lowered supply and catches late errors. Counting pulses, verify reads and security pulses against expected totals exposes extra or missing retries, a restart after an ignored start, and writes out of order.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_READ,
      ST_DONE,
      ST_FAIL
   } seq_st_e;

   typedef enum logic [1:0] {
      PH_PROG,
      PH_VERIFY,
      PH_SEC
   } seq_ph_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [TMR_W-1:0] limit,
   output logic             expired
);

   logic [TMR_W-1:0] cnt;

   assign expired = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (!expired)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/otp_seq_addr.sv
module otp_seq_addr #(
   parameter int ADDR_W    = 17,
   parameter int MAX_TRIES = 25,
   parameter int TRY_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_clr,
   input  logic              addr_inc,
   input  logic              try_clr,
   input  logic              try_inc,
   output logic [ADDR_W-1:0] addr,
   output logic              addr_last,
   output logic              try_last
);

   localparam logic [TRY_W-1:0] TRY_END = TRY_W'(MAX_TRIES - 1);

   logic [TRY_W-1:0] tries;

   assign addr_last = (addr == '1);
   assign try_last  = (tries == TRY_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (addr_clr)
         addr <= '0;
      else if (addr_inc)
         addr <= addr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tries <= '0;
      else if (try_clr)
         tries <= '0;
      else if (try_inc)
         tries <= tries + 1'b1;
   end

endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
   import otp_seq_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int TMR_W     = 14,
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 12500,
   parameter int HOLD_CYC  = 2,
   parameter int ACC_CYC   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sec_en,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              tmr_expired,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_last,
   input  logic              try_last,
   output seq_st_e           st,
   output seq_ph_e           ph,
   output logic [DATA_W-1:0] exp_data,
   output logic              tmr_clr,
   output logic [TMR_W-1:0]  tmr_limit,
   output logic              addr_clr,
   output logic              addr_inc,
   output logic              try_clr,
   output logic              try_inc,
   output logic [ADDR_W-1:0] fail_addr
);

   localparam logic [TMR_W-1:0] LIM_SETUP = TMR_W'(SETUP_CYC - 1);
   localparam logic [TMR_W-1:0] LIM_PULSE = TMR_W'(PULSE_CYC - 1);
   localparam logic [TMR_W-1:0] LIM_HOLD  = TMR_W'(HOLD_CYC - 1);
   localparam logic [TMR_W-1:0] LIM_READ  = TMR_W'(ACC_CYC - 1);

   seq_st_e st_nxt;
   seq_ph_e ph_nxt;
   logic    sec_q;
   logic    cmp_ok;

   assign cmp_ok  = (rd_data == exp_data);
   assign tmr_clr = (st_nxt != st);

   always_comb begin
      unique case (st)
         ST_SETUP: tmr_limit = LIM_SETUP;
         ST_PULSE: tmr_limit = LIM_PULSE;
         ST_HOLD:  tmr_limit = LIM_HOLD;
         ST_READ:  tmr_limit = LIM_READ;
         default:  tmr_limit = '0;
      endcase
   end

   always_comb begin
      st_nxt   = st;
      ph_nxt   = ph;
      addr_clr = 1'b0;
      addr_inc = 1'b0;
      try_clr  = 1'b0;
      try_inc  = 1'b0;
      unique case (st)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start) begin
               st_nxt   = ST_FETCH;
               ph_nxt   = PH_PROG;
               addr_clr = 1'b1;
               try_clr  = 1'b1;
            end
         end
         ST_FETCH: begin
            if (rsp_valid)
               st_nxt = (ph == PH_PROG) ? ST_SETUP : ST_READ;
         end
         ST_SETUP: if (tmr_expired) st_nxt = ST_PULSE;
         ST_PULSE: if (tmr_expired) st_nxt = ST_HOLD;
         ST_HOLD: begin
            if (tmr_expired)
               st_nxt = (ph == PH_SEC) ? ST_DONE : ST_READ;
         end
         ST_READ: begin
            if (tmr_expired) begin
               if (ph == PH_PROG) begin
                  if (cmp_ok) begin
                     try_clr = 1'b1;
                     st_nxt  = ST_FETCH;
                     if (addr_last) begin
                        ph_nxt   = PH_VERIFY;
                        addr_clr = 1'b1;
                     end else begin
                        addr_inc = 1'b1;
                     end
                  end else if (try_last) begin
                     st_nxt = ST_FAIL;
                  end else begin
                     try_inc = 1'b1;
                     st_nxt  = ST_SETUP;
                  end
               end else begin
                  if (!cmp_ok) begin
                     st_nxt = ST_FAIL;
                  end else if (!addr_last) begin
                     addr_inc = 1'b1;
                     st_nxt   = ST_FETCH;
                  end else if (sec_q) begin
                     ph_nxt = PH_SEC;
                     st_nxt = ST_SETUP;
                  end else begin
                     st_nxt = ST_DONE;
                  end
               end
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_PROG;
         sec_q     <= 1'b0;
         exp_data  <= '0;
         fail_addr <= '0;
      end else begin
         st <= st_nxt;
         ph <= ph_nxt;
         if ((st == ST_IDLE || st == ST_DONE || st == ST_FAIL) && start)
            sec_q <= sec_en;
         if (st == ST_FETCH && rsp_valid)
            exp_data <= rsp_data;
         if (st_nxt == ST_FAIL && st != ST_FAIL)
            fail_addr <= addr;
      end
   end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
   import otp_seq_pkg::*;
#(
   parameter int          ADDR_W    = 17,
   parameter int          DATA_W    = 8,
   parameter int          CLK_MHZ   = 125,
   parameter int          PULSE_NS  = 100000,
   parameter int          MAX_TRIES = 25,
   parameter int          SETUP_CYC = 2,
   parameter int          HOLD_CYC  = 2,
   parameter int          ACC_CYC   = 3,
   parameter bit          SEC_LEVEL = 1'b1,
   parameter logic [7:0]  SEC_BYTE  = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sec_en,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              pgm_n,
   output logic              oe_n,
   output logic              vpp_hi,
   output logic              sec_sel,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr
);

   localparam int PULSE_CYC = (CLK_MHZ * PULSE_NS) / 1000;
   localparam int LONGEST   = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, ACC_CYC);
   localparam int TMR_W     = $clog2(LONGEST + 1);
   localparam int TRY_W     = $clog2(MAX_TRIES + 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("otp_seq: pulse length rounds to zero cycles");
      end
      if (SETUP_CYC < 1 || HOLD_CYC < 1 || ACC_CYC < 1) begin : g_bad_phase
         $error("otp_seq: every bus phase needs at least one cycle");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("otp_seq: attempt limit must be positive");
      end
      if (ADDR_W < 1 || DATA_W != 8) begin : g_bad_width
         $error("otp_seq: byte-wide memory with a non-empty address bus required");
      end
   endgenerate

   logic [ADDR_W-1:0] sec_addr;

   generate
      if (SEC_LEVEL) begin : g_sec_high
         assign sec_addr = '1;
      end else begin : g_sec_low
         assign sec_addr = '0;
      end
   endgenerate

   seq_st_e           st;
   seq_ph_e           ph;
   logic [DATA_W-1:0] exp_data;
   logic              tmr_clr;
   logic [TMR_W-1:0]  tmr_limit;
   logic              tmr_expired;
   logic              addr_clr;
   logic              addr_inc;
   logic              try_clr;
   logic              try_inc;
   logic [ADDR_W-1:0] addr;
   logic              addr_last;
   logic              try_last;
   logic              drive_phase;

   otp_seq_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .limit   (tmr_limit),
      .expired (tmr_expired)
   );

   otp_seq_addr #(
      .ADDR_W    (ADDR_W),
      .MAX_TRIES (MAX_TRIES),
      .TRY_W     (TRY_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_clr  (addr_clr),
      .addr_inc  (addr_inc),
      .try_clr   (try_clr),
      .try_inc   (try_inc),
      .addr      (addr),
      .addr_last (addr_last),
      .try_last  (try_last)
   );

   otp_seq_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .TMR_W     (TMR_W),
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .ACC_CYC   (ACC_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .sec_en      (sec_en),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .rd_data     (mem_dq_in),
      .tmr_expired (tmr_expired),
      .addr        (addr),
      .addr_last   (addr_last),
      .try_last    (try_last),
      .st          (st),
      .ph          (ph),
      .exp_data    (exp_data),
      .tmr_clr     (tmr_clr),
      .tmr_limit   (tmr_limit),
      .addr_clr    (addr_clr),
      .addr_inc    (addr_inc),
      .try_clr     (try_clr),
      .try_inc     (try_inc),
      .fail_addr   (fail_addr)
   );

   assign drive_phase = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);

   always_comb begin
      sec_sel    = drive_phase && (ph == PH_SEC);
      mem_dq_oe  = drive_phase;
      pgm_n      = (st != ST_PULSE);
      oe_n       = (st != ST_READ);
      vpp_hi     = (ph != PH_VERIFY) && (drive_phase || st == ST_READ);
      mem_addr   = sec_sel ? sec_addr : addr;
      mem_dq_out = sec_sel ? DATA_W'(SEC_BYTE) : exp_data;
      req_valid  = (st == ST_FETCH);
      req_addr   = addr;
      busy       = (st != ST_IDLE) && (st != ST_DONE) && (st != ST_FAIL);
      done       = (st == ST_DONE);
      fail       = (st == ST_FAIL);
   end

endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 12500
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe,
   input logic              pgm_n,
   input logic              oe_n,
   input logic              vpp_hi,
   input logic              sec_sel,
   input logic              busy,
   input logic              done,
   input logic              fail
);

   localparam int LW = $clog2(PULSE_CYC + 2);

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (pgm_n)
         low_cnt <= '0;
      else
         low_cnt <= low_cnt + 1'b1;
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgm_n) |-> (low_cnt == LW'(PULSE_CYC))); // R1
   AST_PULSE_CONDS: assert property (@(posedge clk) disable iff (!rst_n)
      !pgm_n |-> (vpp_hi && mem_dq_oe && oe_n)); // R1
   AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_n && $past(!pgm_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R1
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !mem_dq_oe); // R2
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pgm_n && oe_n && !req_valid && !vpp_hi)); // R6
   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail); // R6
   AST_SEC_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_sel |-> (vpp_hi && oe_n)); // R8
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail)); // R9
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr))); // R12
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid) |=> !req_valid); // R12

endmodule

bind otp_seq otp_seq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PULSE_CYC (PULSE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe),
   .pgm_n      (pgm_n),
   .oe_n       (oe_n),
   .vpp_hi     (vpp_hi),
   .sec_sel    (sec_sel),
   .busy       (busy),
   .done       (done),
   .fail       (fail)
);

// File: tb/otp_seq_tb.sv
`timescale 1ns/1ps
module otp_seq_tb;

   localparam int         AW    = 3;
   localparam int         NLOC  = 1 << AW;
   localparam int         PCYC  = 10;
   localparam int         TRIES = 25;
   localparam logic [7:0] SECB  = 8'h3C;

   typedef struct packed {
      int haddr;    // address needing extra pulses
      int hneed;    // pulses it needs before taking data
      int drift;    // disturb reads at lowered supply
      int daddr;    // disturbed address
      int sec;      // request security write
      int x_done;
      int x_fail;
      int x_faddr;
      int x_pulses; // array pulses
      int x_vreads; // verify-pass reads
      int x_secp;   // security pulses
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{0, 1,  0, 0, 0, 1, 0, 0, 8,  8, 0},
      '{5, 25, 0, 0, 0, 1, 0, 0, 32, 8, 0},
      '{3, 26, 0, 0, 0, 0, 1, 3, 28, 0, 0},
      '{0, 1,  1, 6, 0, 0, 1, 6, 8,  7, 0},
      '{2, 2,  0, 0, 1, 1, 0, 0, 9,  8, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          sec_en = 1'b0;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic          rsp_valid = 1'b0;
   logic [7:0]    rsp_data = 8'h00;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_dq_out;
   logic          mem_dq_oe;
   logic [7:0]    mem_dq_in;
   logic          pgm_n, oe_n, vpp_hi, sec_sel, busy, done, fail;
   logic [AW-1:0] fail_addr;

   always #4 clk = ~clk;

   otp_seq #(
      .ADDR_W    (AW),
      .DATA_W    (8),
      .CLK_MHZ   (125),
      .PULSE_NS  (80),
      .MAX_TRIES (TRIES),
      .SEC_BYTE  (SECB)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .sec_en     (sec_en),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_dq_in  (mem_dq_in),
      .pgm_n      (pgm_n),
      .oe_n       (oe_n),
      .vpp_hi     (vpp_hi),
      .sec_sel    (sec_sel),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .fail_addr  (fail_addr)
   );

   function automatic logic [7:0] want(input int a);
      return 8'((a * 37 + 17) & 8'hFF);
   endfunction

   // memory model configuration, set by the stimulus
   int            cfg_haddr = 0;
   int            cfg_hneed = 1;
   logic          cfg_drift = 1'b0;
   logic [AW-1:0] cfg_daddr = '0;
   logic          model_clr = 1'b0;

   // memory model state
   logic [7:0] mem [NLOC];
   int         pcnt [NLOC];
   int         tot_pulses, sec_pulses, vreads, low_c, width_err, strobe_err;
   logic       sec_ok;
   logic       pgm_q, oe_q;

   assign mem_dq_in = mem[mem_addr] ^
      ((cfg_drift && !vpp_hi && mem_addr == cfg_daddr) ? 8'h01 : 8'h00);

   always @(negedge clk) begin
      if (model_clr) begin
         for (int i = 0; i < NLOC; i++) begin
            mem[i]  = 8'hFF;
            pcnt[i] = 0;
         end
         tot_pulses = 0; sec_pulses = 0; vreads = 0; low_c = 0;
         width_err = 0; strobe_err = 0; sec_ok = 1'b1;
         pgm_q = 1'b1; oe_q = 1'b1;
      end else begin
         if (!pgm_n) begin
            low_c++;
            if (!(vpp_hi && mem_dq_oe && oe_n)) strobe_err++;
         end
         if (pgm_n && !pgm_q) begin
            if (low_c != PCYC) width_err++;
            low_c = 0;
            if (sec_sel) begin
               sec_pulses++;
               if (mem_addr != '1 || mem_dq_out != SECB) sec_ok = 1'b0;
            end else begin
               pcnt[mem_addr]++;
               tot_pulses++;
               if (pcnt[mem_addr] >= ((int'(mem_addr) == cfg_haddr) ? cfg_hneed : 1))
                  mem[mem_addr] = mem[mem_addr] & mem_dq_out;
            end
         end
         if (!oe_n && oe_q && !vpp_hi) vreads++;
         pgm_q = pgm_n;
         oe_q  = oe_n;
      end
   end

   // expected-data responder with a two-cycle latency
   int            rsp_wait = 0;
   int            ord_err = 0;
   int            hs_err = 0;
   logic [AW-1:0] next_req = '0;
   logic          req_seen = 1'b0;
   logic [AW-1:0] held_addr = '0;

   always @(negedge clk) begin
      if (model_clr) begin
         next_req = '0; ord_err = 0; hs_err = 0; req_seen = 1'b0; rsp_wait = 0;
         rsp_valid = 1'b0;
      end else if (rsp_valid) begin
         rsp_valid = 1'b0;
         req_seen  = 1'b0;
      end else if (req_valid) begin
         if (!req_seen) begin
            if (req_addr != next_req) ord_err++;
            next_req  = req_addr + 1'b1;
            held_addr = req_addr;
            req_seen  = 1'b1;
         end else if (req_addr != held_addr) begin
            hs_err++;
         end
         if (rsp_wait == 2) begin
            rsp_valid = 1'b1;
            rsp_data  = want(int'(req_addr));
            rsp_wait  = 0;
         end else begin
            rsp_wait++;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic clear_model();
      model_clr = 1'b1;
      @(negedge clk);
      model_clr = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      model_clr = 1'b1;
      repeat (5) @(negedge clk);
      model_clr = 1'b0;

      // R11: reset state
      chk("R11 busy in reset", int'(busy), 0);
      chk("R11 pgm_n in reset", int'(pgm_n), 1);
      chk("R11 oe_n in reset", int'(oe_n), 1);
      chk("R11 vpp_hi in reset", int'(vpp_hi), 0);
      chk("R11 flags in reset", int'(done) + int'(fail) + int'(req_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 idle after reset", int'(busy) + int'(done) + int'(fail), 0);

      for (int k = 0; k < 5; k++) begin
         cfg_haddr = VEC[k].haddr;
         cfg_hneed = VEC[k].hneed;
         cfg_drift = (VEC[k].drift != 0);
         cfg_daddr = AW'(VEC[k].daddr);
         sec_en    = (VEC[k].sec != 0);
         clear_model();
         pulse_start();
         // R10: start from idle/done/fail clears flags and runs
         chk($sformatf("R10 v%0d restart flags", k), int'(done) + int'(fail), 0);
         chk($sformatf("R10 v%0d busy after start", k), int'(busy), 1);
         if (k == 0) begin
            repeat (40) @(negedge clk);
            pulse_start();
            chk("R10 start while busy ignored", int'(busy), 1);
         end
         while (!(done || fail)) @(negedge clk);
         repeat (5) @(negedge clk);
         chk($sformatf("R9 v%0d done", k), int'(done), VEC[k].x_done);
         chk($sformatf("R6 R7 v%0d fail", k), int'(fail), VEC[k].x_fail);
         if (VEC[k].x_fail != 0)
            chk($sformatf("R6 R7 v%0d fail_addr", k), int'(fail_addr), VEC[k].x_faddr);
         chk($sformatf("R3 v%0d array pulses", k), tot_pulses, VEC[k].x_pulses);
         chk($sformatf("R5 v%0d verify reads", k), vreads, VEC[k].x_vreads);
         chk($sformatf("R8 v%0d security pulses", k), sec_pulses, VEC[k].x_secp);
         chk($sformatf("R1 v%0d pulse width", k), width_err, 0);
         chk($sformatf("R1 v%0d strobe conditions", k), strobe_err, 0);
         chk($sformatf("R4 v%0d address order", k), ord_err, 0);
         chk($sformatf("R12 v%0d request hold", k), hs_err, 0);
         if (VEC[k].x_done != 0) begin
            for (int a = 0; a < NLOC; a++)
               chk($sformatf("R2 R4 v%0d content @%0d", k, a), int'(mem[a]), int'(want(a)));
         end
         if (VEC[k].x_secp != 0)
            chk("R8 security address and byte", int'(sec_ok), 1);
         // R6: nothing moves after the run stops
         begin
            int p0, v0;
            p0 = tot_pulses; v0 = vreads;
            repeat (60) @(negedge clk);
            chk($sformatf("R6 v%0d quiet after stop", k), tot_pulses + vreads, p0 + v0);
         end
      end

      // R11: reset in the middle of a run
      cfg_haddr = 0; cfg_hneed = 1; cfg_drift = 1'b0; sec_en = 1'b0;
      clear_model();
      pulse_start();
      repeat (30) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 mid-run reset pgm_n", int'(pgm_n), 1);
      chk("R11 mid-run reset busy", int'(busy), 0);
      chk("R11 mid-run reset vpp_hi", int'(vpp_hi), 0);
      rst_n = 1'b1;
      repeat (50) @(negedge clk);
      chk("R11 stays idle after reset", int'(busy) + int'(req_valid), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule